// File: doc/BRIEF.md
# Converter Sample Buffer with Half-Full Interrupt

This block sits between a converter sequencer and a processor. Each result strobe from the sequencer writes one 12-bit sample into a circular store. The processor reads samples from the other side with a read strobe. Because a half-full level acts as the interrupt request, the processor can collect a whole block per interrupt and does not need to service every conversion.

Read and write strobes are independent and may arrive in the same cycle, so the processor can drain the store while the converter keeps filling it. Both sides run on one clock. When no free entry remains, the block raises an inhibit output that holds off the converter. A write that still arrives while the store is full is dropped, and a sticky overflow bit records it. Reset clears the pointers and the occupancy, and it also sets every stored entry to zero.

Top module: `adc_sample_buffer`

## Requirements
- R1: A write strobe while the buffer is not full stores `wr_data_i`. Samples are read out in the order they were written.
- R2: `rd_data_o` shows the oldest stored sample combinationally. A read strobe while not empty removes that sample, and the next one appears after the clock edge.
- R3: `empty_o` is high exactly when the occupancy is zero. A read strobe while empty, with no write, changes nothing.
- R4: `full_o` is high exactly when the occupancy equals DEPTH (256 by default). `inhibit_o` is high exactly when `full_o` is high.
- R5: A write strobe while full with no read strobe is discarded, leaves the occupancy and contents unchanged, and sets `overflow_o`. The bit stays high until reset.
- R6: `half_full_o` is high when the occupancy is at least DEPTH/2. It is a level that stays high until the occupancy falls below DEPTH/2.
- R7: Read and write strobes together while full both take effect. The buffer stays full, the oldest sample leaves, the new sample enters, and no overflow is recorded.
- R8: Read and write strobes together while empty store the new sample and ignore the read, leaving an occupancy of one.
- R9: An active-low reset clears the occupancy, the pointers and `overflow_o`, and sets every stored entry to zero. Each entry later exposed at `rd_data_o` while empty reads 0.
- R10: The occupancy changes by at most one per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both sides |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Result strobe from the sequencer |
| wr_data_i | input | 12 | Sample to store |
| rd_i | input | 1 | Read strobe from the processor |
| rd_data_o | output | 12 | Oldest stored sample |
| half_full_o | output | 1 | Interrupt request, occupancy at least DEPTH/2 |
| full_o | output | 1 | No free entry |
| empty_o | output | 1 | No stored sample |
| inhibit_o | output | 1 | Holds off the converter while full |
| overflow_o | output | 1 | Sticky flag for a dropped sample |

## Verification
The assertions check the following properties on every cycle:
- the occupancy moves by at most one per cycle;
- full and empty are never high together;
- a dropped write leads to full and overflow, and overflow stays high;
- half-full cannot fall without a read;
- simultaneous strobes keep a full buffer full and leave an empty buffer with exactly one entry.

Only the bench scenarios can show the data properties: that samples leave in write order, that the values at each half-full threshold crossing are correct, and that after reset every entry reads zero. The bench covers these with a full sweep of a 16-entry configuration and a long pseudo-random strobe mix checked against an arithmetic queue model.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;

  typedef struct packed {
    logic wr_ok;   // write takes effect
    logic rd_ok;   // read takes effect
    logic drop;    // write discarded while full
  } buf_op_t;

endpackage

// File: rtl/adc_buf_ctrl.sv
module adc_buf_ctrl
  import adc_buf_pkg::*;
(
  input  logic    wr_i,
  input  logic    rd_i,
  input  logic    full_i,
  input  logic    empty_i,
  output buf_op_t op_o
);

  // a read frees a slot in the same cycle, so a write at full still fits
  always_comb begin
    op_o.rd_ok = rd_i && !empty_i;
    op_o.wr_ok = wr_i && (!full_i || rd_i);
    op_o.drop  = wr_i && full_i && !rd_i;
  end

endmodule

// File: rtl/adc_buf_ptr.sv
module adc_buf_ptr
  import adc_buf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  buf_op_t          op_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             half_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic             ovf_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (op_i.wr_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (op_i.rd_ok) rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({op_i.wr_ok, op_i.rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (op_i.drop) ovf_q <= 1'b1;
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign full_o   = (cnt_q == CNT_FULL);
  assign empty_o  = (cnt_q == '0);
  assign half_o   = (cnt_q >= CNT_HALF);
  assign ovf_o    = ovf_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 ||
              cnt_q == $past(cnt_q) - 1'b1)); // R10
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R3
  AST_DROP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.drop |=> (full_o && ovf_o)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R5
  AST_HALF_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_o && !op_i.rd_ok) |=> half_o); // R6
  AST_EMPTY_RD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !op_i.wr_ok) |=> empty_o); // R3

endmodule

// File: rtl/adc_buf_mem.sv
module adc_buf_mem #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 256,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] ent [DEPTH];

  // per-entry registers so reset clears the whole store
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (wr_en_i && wr_ptr_i == PTR_W'(g))  q <= wr_data_i;
    end
    assign ent[g] = q;
  end

  assign rd_data_o = ent[rd_ptr_i];

endmodule

// File: rtl/adc_sample_buffer.sv
module adc_sample_buffer
  import adc_buf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 256,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              half_full_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              inhibit_o,
  output logic              overflow_o
);

  buf_op_t          op;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full, empty;

  adc_buf_ctrl u_ctrl (
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .full_i  (full),
    .empty_i (empty),
    .op_o    (op)
  );

  adc_buf_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .full_o   (full),
    .empty_o  (empty),
    .half_o   (half_full_o),
    .ovf_o    (overflow_o)
  );

  adc_buf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (op.wr_ok),
    .wr_ptr_i  (wr_ptr),
    .wr_data_i (wr_data_i),
    .rd_ptr_i  (rd_ptr),
    .rd_data_o (rd_data_o)
  );

  assign full_o    = full;
  assign empty_o   = empty;
  assign inhibit_o = full;

  AST_BOTH_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_i && rd_i) |=> (full_o && $stable(overflow_o))); // R7
  AST_BOTH_AT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && wr_i && rd_i) |=> (!empty_o && (DEPTH == 1 || !full_o))); // R8
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && full_o) |=> full_o); // R5

endmodule

// File: tb/adc_sample_buffer_tb_top.sv
module adc_sample_buffer_tb_top;

  localparam int DW = 12;
  localparam int D  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdat = '0;
  logic [DW-1:0] rdat;
  logic          half, full, empty, inh, ovf;

  int total = 0, bad = 0;
  int mq[$];
  bit m_ovf = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_sample_buffer #(.DATA_W(DW), .DEPTH(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wdat), .rd_i(rd),
    .rd_data_o(rdat), .half_full_o(half), .full_o(full), .empty_o(empty),
    .inhibit_o(inh), .overflow_o(ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string dtag);
    int n = mq.size();
    chk("R3 empty", int'(empty), int'(n == 0));
    chk("R4 full", int'(full), int'(n == D));
    chk("R4 inhibit", int'(inh), int'(n == D));
    chk("R6 half", int'(half), int'(n >= D / 2));
    chk("R5 overflow", int'(ovf), int'(m_ovf));
    if (n > 0) chk(dtag, int'(rdat), mq[0]);
  endtask

  // drive at negedge, update model at posedge, sample 5 ns later
  task automatic step(input bit w, input bit r, input int d);
    bit rok, wok;
    @(negedge clk);
    wr = w; rd = r; wdat = DW'(d);
    @(posedge clk);
    rok = r && mq.size() > 0;
    wok = w && (mq.size() < D || r);
    if (w && mq.size() == D && !r) m_ovf = 1'b1;
    if (rok) void'(mq.pop_front());
    if (wok) mq.push_back(d & ((1 << DW) - 1));
    #5;
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mq.delete();
    m_ovf = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lfsr;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 reset empty", int'(empty), 1);
    chk("R9 reset full", int'(full), 0);
    chk("R9 reset overflow", int'(ovf), 0);
    chk("R9 reset half", int'(half), 0);
    chk("R9 reset data", int'(rdat), 0);

    // fill to full, flags checked at every occupancy
    for (int i = 0; i < D; i++) begin
      step(1, 0, i * 37 + 5);
      chk_all("R1 head");
    end
    // dropped writes
    step(1, 0, 12'hABC);
    chk_all("R5 head unchanged");
    step(1, 0, 12'h123);
    chk_all("R5 head unchanged");
    // simultaneous at full
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 1000 + i);
      chk_all("R7 head");
    end
    // drain in order, half level falls below D/2
    for (int i = 0; i < D; i++) begin
      step(0, 1, 0);
      chk_all("R2 order");
    end
    // read on empty ignored
    step(0, 1, 0);
    chk_all("R3 empty read");
    step(0, 1, 0);
    chk_all("R3 empty read");
    // simultaneous at empty
    step(1, 1, 777);
    chk_all("R8 head");
    chk("R8 count one", int'(empty), 0);
    step(0, 1, 0);
    chk_all("R8 drained");

    // pseudo-random strobe mix against queue model
    do_reset();
    lfsr = 32'h1ACE;
    for (int i = 0; i < 4000; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      // bias writes or reads in alternating phases to visit full and empty
      if ((i / 200) % 2 == 0)
        step((lfsr & 3) != 0, (lfsr & 12) == 0, lfsr & 12'hFFF);
      else
        step((lfsr & 12) == 0, (lfsr & 3) != 0, lfsr & 12'hFFF);
      chk_all("R10 head");
    end

    // reset clears every entry
    do_reset();
    for (int i = 0; i < D; i++) step(1, 0, 12'hF00 + i + 1);
    do_reset();
    for (int k = 0; k < D; k++) begin
      #1;
      chk("R9 cleared entry", int'(rdat), 0);
      step(1, 0, 12'h055);
      step(0, 1, 0);
      chk_all("R9 head");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule